// File: doc/BRIEF.md
# LDPC Early-Termination Data Check

This block lets an iterative quasi-cyclic LDPC decoder stop as soon as its data bits have settled, without waiting for the weakly protected parity bits to converge. The parity part of the code is dual-diagonal. When every block row of the parity-check matrix is added together, the weight-2 parity columns cancel. What remains is a single z-bit equation that covers all data sub-blocks and only the first parity sub-block, p0. The unit evaluates that one equation instead of all m parity checks.

After each decoding iteration the decoder streams its hard decisions into the unit, one z-bit word per cycle. The data sub-blocks come first, in column order 0 to KB-1, and p0 follows with `in_last` set. For each data column, the unit XORs together the copies of the word rotated by every non-negative shift in that column of the compile-time base matrix. It folds the result into a z-bit accumulator. When p0 arrives it is XORed in unrotated. One cycle later `done` pulses, with `success` high if the reduced syndrome is all zero. The accumulator is then clear for the next iteration.

The input is a valid/ready stream. A word is consumed only on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low only during the single result cycle. A source that offers a word during that cycle must hold it until `in_ready` returns. The upper parity sub-blocks p1..p(MB-1) are never requested.

Top module: `ldpc_stop_check`

## Requirements
- R1: Base-matrix entry (i,j) is stored as a signed SHIFT_W-bit field at bit offset (i*KB+j)*SHIFT_W of `SHIFTS`. A negative entry contributes nothing. A non-negative entry s contributes the word y with y[r] = d[(r+s) mod Z], where d is data sub-block j.
- R2: The reduced syndrome is the XOR of all contributions from R1 over every row and data column, XORed with p0 without rotation. `success` is 1 exactly when all Z bits of this syndrome are 0.
- R3: A frame is KB data words in column order followed by one p0 word carrying `in_last`. `in_last` is set on the (KB+1)-th accepted word of a frame and on no other word.
- R4: `done` is high in the cycle after the `in_last` word is accepted, and in no other cycle. `success` is 0 whenever `done` is 0.
- R5: `done` lasts exactly one cycle. Each frame's result is independent of earlier frames.
- R6: `in_ready` is 0 during the result cycle and 1 otherwise. A word offered during the result cycle is not consumed.
- R7: A synchronous reset `rst` forces `done` and `success` to 0 and discards a partly received frame.
- R8: Flipping any single bit of a data word or of p0 in a valid codeword changes the result exactly as the syndrome of R2 predicts. The result never depends on the parity sub-blocks beyond p0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit can accept a word this cycle |
| in_data | input | Z | Hard-decision sub-block word |
| in_last | input | 1 | Marks the p0 word that ends a frame |
| done | output | 1 | One-cycle result strobe |
| success | output | 1 | Reduced syndrome was zero; meaningful with done |

## Verification
The checker takes for granted that the source frames its words correctly: exactly KB data words, then one p0 word with `in_last`, and no `in_last` anywhere else. It also assumes the source keeps an offered word stable until it is accepted. The bench never breaks these assumptions. It drives every frame through one push task that waits on `in_ready`, holds the word that is stalled during the result cycle, and only interrupts a frame by asserting reset. Within these limits it sweeps random codewords, all single-bit corruptions of data and p0, back-to-back frames and a reset in the middle of a frame.

// File: rtl/ldpc_stop_pkg.sv
package ldpc_stop_pkg;
  localparam int SHIFT_W = 8;

  // map any shift onto 0..z-1
  function automatic int wrap_shift(input int s, input int z);
    return ((s % z) + z) % z;
  endfunction
endpackage

// File: rtl/ldpc_col_combine.sv
module ldpc_col_combine
  import ldpc_stop_pkg::*;
#(
  parameter int Z   = 8,
  parameter int MB  = 3,
  parameter int KB  = 4,
  parameter int COL = 0,
  parameter logic [MB*KB*SHIFT_W-1:0] SHIFTS = '0
) (
  input  logic [Z-1:0] din,
  output logic [Z-1:0] contrib
);
  logic [Z-1:0] term [MB];

  for (genvar gi = 0; gi < MB; gi++) begin : g_row
    localparam logic signed [SHIFT_W-1:0] ENTRY = SHIFTS[(gi*KB+COL)*SHIFT_W +: SHIFT_W];
    if (ENTRY < 0) begin : g_zero
      assign term[gi] = '0;
    end else begin : g_rot
      localparam int AMT = wrap_shift(int'(ENTRY), Z);
      for (genvar gb = 0; gb < Z; gb++) begin : g_bit
        assign term[gi][gb] = din[(gb + AMT) % Z];
      end
    end
  end

  always_comb begin
    contrib = '0;
    for (int i = 0; i < MB; i++) contrib = contrib ^ term[i];
  end
endmodule

// File: rtl/ldpc_syn_acc.sv
module ldpc_syn_acc #(
  parameter int Z  = 8,
  parameter int KB = 4,
  parameter int CW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic                 is_last,
  input  logic [CW-1:0]        col,
  input  logic [KB-1:0][Z-1:0] contribs,
  input  logic [Z-1:0]         p_word,
  output logic                 final_zero
);
  logic [Z-1:0] acc;
  logic [Z-1:0] sel;

  always_comb begin
    sel = '0;
    for (int j = 0; j < KB; j++)
      if (col == CW'(j)) sel = contribs[j];
  end

  assign final_zero = ((acc ^ p_word) == '0);

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (take) begin
      if (is_last)    acc <= '0;
      else            acc <= acc ^ sel;
    end
  end
endmodule

// File: rtl/ldpc_stop_ctrl.sv
module ldpc_stop_ctrl #(
  parameter int KB = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          final_zero,
  output logic          in_ready,
  output logic          take,
  output logic [CW-1:0] col,
  output logic          done,
  output logic          success
);
  localparam logic [CW-1:0] COL_MAX = CW'(KB);

  assign in_ready = !done;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      col     <= '0;
      done    <= 1'b0;
      success <= 1'b0;
    end else begin
      done    <= take && in_last;
      success <= take && in_last && final_zero;
      if (take) begin
        if (in_last)             col <= '0;
        else if (col != COL_MAX) col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldpc_stop_check.sv
module ldpc_stop_check
  import ldpc_stop_pkg::*;
#(
  parameter int Z  = 8,
  parameter int KB = 4,
  parameter int MB = 3,
  // row 2: -1 4 6 0 | row 1: 2 -1 7 1 | row 0: 0 3 -1 5  (col 0 at low bits)
  parameter logic [MB*KB*SHIFT_W-1:0] SHIFTS = {
    8'h00, 8'h06, 8'h04, 8'hFF,
    8'h01, 8'h07, 8'hFF, 8'h02,
    8'h05, 8'hFF, 8'h03, 8'h00 }
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [Z-1:0] in_data,
  input  logic         in_last,
  output logic         done,
  output logic         success
);
  localparam int CW = $clog2(KB + 1);

  logic [KB-1:0][Z-1:0] contribs;
  logic [CW-1:0]        col;
  logic                 take;
  logic                 final_zero;

  for (genvar gj = 0; gj < KB; gj++) begin : g_col
    ldpc_col_combine #(
      .Z(Z), .MB(MB), .KB(KB), .COL(gj), .SHIFTS(SHIFTS)
    ) u_comb (
      .din    (in_data),
      .contrib(contribs[gj])
    );
  end

  ldpc_syn_acc #(.Z(Z), .KB(KB), .CW(CW)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .is_last   (in_last),
    .col       (col),
    .contribs  (contribs),
    .p_word    (in_data),
    .final_zero(final_zero)
  );

  ldpc_stop_ctrl #(.KB(KB), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .final_zero(final_zero),
    .in_ready  (in_ready),
    .take      (take),
    .col       (col),
    .done      (done),
    .success   (success)
  );
endmodule

// File: rtl/ldpc_stop_check_sva.sv
module ldpc_stop_check_sva #(
  parameter int KB = 4
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic done,
  input logic success
);
  int  words;
  logic acc_w;
  assign acc_w = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)        words <= 0;
    else if (acc_w) words <= in_last ? 0 : words + 1;
  end

  // R4: success only accompanies done
  a_r4_success_with_done: assert property (@(posedge clk) disable iff (rst)
    success |-> done);
  // R4: accepted last word yields done next cycle
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (acc_w && in_last) |=> done);
  // R4: no done without an accepted last word
  a_r4_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !(acc_w && in_last) |=> !done);
  // R5: single-cycle result strobe
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: hold-off during result cycle
  a_r6_hold_off: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);
  a_r6_ready_otherwise: assert property (@(posedge clk) disable iff (rst)
    !done |-> in_ready);
  // R3: framing assumption on the source
  a_r3_last_position: assert property (@(posedge clk) disable iff (rst)
    acc_w |-> (in_last == (words == KB)));
endmodule

bind ldpc_stop_check ldpc_stop_check_sva #(.KB(KB)) u_sva (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_last (in_last),
  .done    (done),
  .success (success)
);

// File: tb/tb_ldpc_stop_check.sv
`timescale 1ns/1ps
module tb_ldpc_stop_check;
  localparam int Z  = 8;
  localparam int KB = 4;
  localparam int MB = 3;
  localparam logic [MB*KB*8-1:0] TBL = {
    8'h00, 8'h06, 8'h04, 8'hFF,
    8'h01, 8'h07, 8'hFF, 8'h02,
    8'h05, 8'hFF, 8'h03, 8'h00 };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [Z-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic done, success;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ldpc_stop_check #(.Z(Z), .KB(KB), .MB(MB), .SHIFTS(TBL)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .done(done), .success(success)
  );

  logic [Z-1:0] fd [KB];
  logic [Z-1:0] fp;

  // reduced syndrome from the requirement formulas (R1, R2)
  function automatic logic [Z-1:0] syndrome(input logic [Z-1:0] p0);
    logic [Z-1:0] y = p0;
    for (int i = 0; i < MB; i++)
      for (int j = 0; j < KB; j++) begin
        int s = int'($signed(TBL[(i*KB+j)*8 +: 8]));
        if (s >= 0)
          for (int r = 0; r < Z; r++) y[r] = y[r] ^ fd[j][(r + s) % Z];
      end
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [Z-1:0] w, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_frame();
    for (int j = 0; j < KB; j++) push(fd[j], 1'b0);
    push(fp, 1'b1);
  endtask

  task automatic run_frame(input string tag);
    logic exp = (syndrome(fp) == '0);
    send_frame();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(done === 1'b1, {tag, " R4 done"}, int'(done), 1);
    chk(success === exp, {tag, " R2 success"}, int'(success), int'(exp));
    chk(in_ready === 1'b0, {tag, " R6 ready low"}, int'(in_ready), 0);
    @(negedge clk);
    chk(done === 1'b0 && success === 1'b0, {tag, " R5 pulse end"}, int'({done, success}), 0);
  endtask

  task automatic random_codeword();
    for (int j = 0; j < KB; j++) fd[j] = Z'($urandom);
    fp = '0;
    fp = syndrome('0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0 && success === 1'b0, "R7 reset outputs", int'({done, success}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, "R6 ready idle", int'(in_ready), 1);

    // all-zero word is a codeword
    for (int j = 0; j < KB; j++) fd[j] = '0;
    fp = '0;
    run_frame("zero R2");

    // random valid codewords (R1, R2)
    for (int n = 0; n < 20; n++) begin
      random_codeword();
      run_frame("codeword R1");
    end

    // every single-bit corruption of data and p0 (R8)
    for (int n = 0; n < 3; n++) begin
      for (int b = 0; b < (KB + 1) * Z; b++) begin
        random_codeword();
        if (b < KB * Z) fd[b / Z][b % Z] = ~fd[b / Z][b % Z];
        else            fp[b - KB*Z] = ~fp[b - KB*Z];
        chk(syndrome(fp) != '0, "R8 model sees flip", 0, 1);
        run_frame("flip R8");
      end
    end

    // arbitrary words, result predicted by the model (R2)
    for (int n = 0; n < 10; n++) begin
      for (int j = 0; j < KB; j++) fd[j] = Z'($urandom);
      fp = Z'($urandom);
      run_frame("random R2");
    end

    // word offered during result cycle is held off, not consumed (R6, R8)
    random_codeword();
    send_frame();
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b0;   // an upper parity word
    chk(done === 1'b1 && success === 1'b1, "R5 b2b result", int'({done, success}), 3);
    chk(in_ready === 1'b0, "R6 held off", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    random_codeword();
    fd[0] = fd[0] ^ 8'h11; fp = '0; fp = syndrome('0);
    run_frame("after holdoff R6");

    // reset in the middle of a frame discards it (R7)
    push(8'hFF, 1'b0);
    push(8'h3C, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && success === 1'b0, "R7 mid reset", int'({done, success}), 0);
    rst = 1'b0;
    random_codeword();
    run_frame("post reset R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R4 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule